// File: doc/BRIEF.md
# Peripheral Output Channel Multiplexer

This block connects one computer output port to a set of peripheral output channels. Words reach the peripherals through two handshakes. In the first, a channel raises a data request and the computer answers with an acknowledge strobe. In the second, a channel raises a function request and the computer answers with a function pulse. The 30-bit output bus goes unchanged to every channel. The block holds one selected channel, passes only that channel's requests to the computer, and steers each acknowledge strobe and each function strobe back to that channel alone.

The block checks the top bit of each function word at the start of the pulse. When that bit is 0, the word is a peripheral function. Its lower 29 bits are latched and sent to the selected channel with a one-cycle strobe. When the top bit is 1, the word is an internal command and goes to no channel. For the whole pulse, the function request to the computer is held low. When the pulse ends, the command runs: either a master clear or a channel selection.

Top module: `outchan_mux`

## Requirements
- R1: `ch_data` equals `cpu_data` in every cycle, with no register and no change to any bit.
- R2: After reset, no channel is selected. `cpu_odr`, `cpu_efr`, `ch_ack`, `ch_ef` and `ch_fword` are all 0, even when every channel request is high.
- R3: A function word with bit 29 = 1 and bit 28 = 0 selects the channel whose index is in bits [IDXW-1:0]. The selection takes effect in the first cycle after the pulse ends, and it replaces any previous selection.
- R4: `cpu_odr` follows the `ch_odr` bit of the selected channel in the same cycle. Requests from channels that are not selected are ignored.
- R5: `cpu_efr` follows the `ch_efr` bit of the selected channel in the same cycle. Requests from channels that are not selected are ignored.
- R6: A rising edge of `cpu_ack` makes `ch_ack` of the selected channel high for exactly one cycle, the cycle after the edge. No other channel gets a strobe, and no channel gets one when nothing is selected.
- R7: A function pulse with bit 29 = 0 loads bits 28..0 into `ch_fword`. It also makes `ch_ef` of the selected channel high for exactly one cycle, the cycle after the rising edge.
- R8: A function pulse with bit 29 = 1 raises no `ch_ef` bit and leaves `ch_fword` unchanged.
- R9: While a function pulse with bit 29 = 1 is high, `cpu_efr` is 0, even if the selected channel is requesting.
- R10: A function word with bit 29 = 1 and bit 28 = 1 is a master clear. When the pulse ends, no channel is selected.
- R11: A select command whose index is NCH or more leaves no channel selected.
- R12: While an internal pulse is still high, the old selection stays in force for request forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_data | input | DW | Computer output data bus |
| cpu_ack | input | 1 | Computer output acknowledge |
| cpu_ef | input | 1 | Computer function pulse |
| cpu_odr | output | 1 | Data request to the computer |
| cpu_efr | output | 1 | Function request to the computer |
| ch_odr | input | NCH | Data requests from the channels |
| ch_efr | input | NCH | Function requests from the channels |
| ch_data | output | DW | Data bus sent to all channels |
| ch_fword | output | DW-1 | Latched function word, bits 28..0 |
| ch_ack | output | NCH | Acknowledge strobes to the channels |
| ch_ef | output | NCH | Function strobes to the channels |

## Verification
The assertions check four properties on every cycle:
- At most one acknowledge strobe and at most one function strobe are high at a time.
- Each function strobe lasts one cycle.
- Every acknowledge strobe has an acknowledge edge behind it.
- A forwarded data request always comes from the selected channel, and the function request is low at the start of an internal pulse.

The bench scenarios cover what a single cycle cannot show:
- which channel a select command picks, including when the index is out of range;
- the delay until the selection takes effect after the pulse;
- master clear;
- that the latched function word is kept when a pulse is internal.

// File: rtl/outchan_pkg.sv
// Package: shared command type and function-word bit positions for the
// output channel multiplexer. Assumes a data word of at least 3 bits.
package outchan_pkg;

    // Operation carried by an internal function word (bit DW-2).
    typedef enum logic {
        CMD_SELECT = 1'b0,
        CMD_CLEAR  = 1'b1
    } cmd_e;

endpackage

// File: rtl/outchan_ctrl.sv
// outchan_ctrl: watches the function pulse, classifies each word by its
// top bit, holds internal commands until the pulse ends and keeps the
// one-hot channel selection. Assumes NCH >= 2 and cpu_data stable while
// cpu_ef is high.
module outchan_ctrl
    import outchan_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int DW   = 30,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_ef,
    input  logic [DW-1:0]  cpu_data,
    output logic [NCH-1:0] sel_oh,
    output logic           int_now,
    output logic           per_fire,
    output logic           mclr_apply
);

    localparam int TOPB = DW - 1;
    localparam int OPB  = DW - 2;

    logic            ef_q;
    logic            hold_int;
    cmd_e            hold_cmd;
    logic [IDXW-1:0] hold_idx;
    logic            ef_rise;
    logic            ef_fall;
    logic            sel_apply;
    logic [NCH-1:0]  dec_oh;

    // Edge detection on the function pulse.
    assign ef_rise = cpu_ef & ~ef_q;
    assign ef_fall = ~cpu_ef & ef_q;

    // Internal pulse in progress: decided from the bus on the edge, held after.
    assign int_now = cpu_ef & (ef_rise ? cpu_data[TOPB] : hold_int);

    // A peripheral function word starts on this cycle.
    assign per_fire = ef_rise & ~cpu_data[TOPB];

    assign mclr_apply = ef_fall & hold_int & (hold_cmd == CMD_CLEAR);
    assign sel_apply  = ef_fall & hold_int & (hold_cmd == CMD_SELECT);

    // Decode the held index; an index at or above NCH matches no channel.
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign dec_oh[i] = (hold_idx == IDXW'(i));
    end

    // Track the pulse and capture the command carried by an internal word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ef_q     <= 1'b0;
            hold_int <= 1'b0;
            hold_cmd <= CMD_SELECT;
            hold_idx <= '0;
        end else begin
            ef_q <= cpu_ef;
            if (ef_rise) begin
                hold_int <= cpu_data[TOPB];
                hold_cmd <= cmd_e'(cpu_data[OPB]);
                hold_idx <= cpu_data[IDXW-1:0];
            end else if (ef_fall) begin
                hold_int <= 1'b0;
            end
        end
    end

    // Selection register: changes only when an internal pulse has ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_oh <= '0;
        end else if (mclr_apply) begin
            sel_oh <= '0;
        end else if (sel_apply) begin
            sel_oh <= dec_oh;
        end
    end

endmodule

// File: rtl/outchan_steer.sv
// outchan_steer: turns the acknowledge edge and peripheral function edge
// into one-cycle strobes for the selected channel and latches the 29-bit
// function word. Assumes sel_oh is one-hot or zero.
module outchan_steer #(
    parameter int NCH = 6,
    parameter int DW  = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_ack,
    input  logic [DW-1:0]  cpu_data,
    input  logic [NCH-1:0] sel_oh,
    input  logic           per_fire,
    input  logic           mclr_apply,
    output logic [NCH-1:0] ch_ack,
    output logic [NCH-1:0] ch_ef,
    output logic [DW-2:0]  ch_fword
);

    logic ack_q;
    logic ack_rise;

    assign ack_rise = cpu_ack & ~ack_q;

    // Remember the acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= cpu_ack;
    end

    // Per-channel strobe registers, each high for one cycle per edge.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n || mclr_apply) begin
                ch_ack[i] <= 1'b0;
                ch_ef[i]  <= 1'b0;
            end else begin
                ch_ack[i] <= sel_oh[i] & ack_rise;
                ch_ef[i]  <= sel_oh[i] & per_fire;
            end
        end
    end

    // Latch the lower bits of a peripheral function word; the top bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)        ch_fword <= '0;
        else if (per_fire) ch_fword <= cpu_data[DW-2:0];
    end

endmodule

// File: rtl/outchan_req.sv
// outchan_req: forwards the selected channel's requests to the computer
// without delay; the function request is masked during an internal pulse.
module outchan_req #(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] ch_odr,
    input  logic [NCH-1:0] ch_efr,
    input  logic [NCH-1:0] sel_oh,
    input  logic           int_now,
    output logic           cpu_odr,
    output logic           cpu_efr
);

    // Pick the selected channel's requests through the one-hot mask.
    always_comb begin
        cpu_odr = |(ch_odr & sel_oh);
        cpu_efr = (|(ch_efr & sel_oh)) & ~int_now;
    end

endmodule

// File: rtl/outchan_mux.sv
// outchan_mux: top of the peripheral output channel multiplexer. Sends the
// computer data bus to all channels, keeps one selected channel, forwards
// its requests and steers strobes to it. Assumes the computer keeps the
// bus stable while a function pulse is high.
module outchan_mux #(
    parameter int NCH = 6,
    parameter int DW  = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  cpu_data,
    input  logic           cpu_ack,
    input  logic           cpu_ef,
    output logic           cpu_odr,
    output logic           cpu_efr,
    input  logic [NCH-1:0] ch_odr,
    input  logic [NCH-1:0] ch_efr,
    output logic [DW-1:0]  ch_data,
    output logic [DW-2:0]  ch_fword,
    output logic [NCH-1:0] ch_ack,
    output logic [NCH-1:0] ch_ef
);

    localparam int IDXW = $clog2(NCH);

    logic [NCH-1:0] sel_oh;
    logic           int_now;
    logic           per_fire;
    logic           mclr_apply;

    // Broadcast: wires only.
    assign ch_data = cpu_data;

    outchan_ctrl #(.NCH(NCH), .DW(DW), .IDXW(IDXW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ef     (cpu_ef),
        .cpu_data   (cpu_data),
        .sel_oh     (sel_oh),
        .int_now    (int_now),
        .per_fire   (per_fire),
        .mclr_apply (mclr_apply)
    );

    outchan_steer #(.NCH(NCH), .DW(DW)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ack    (cpu_ack),
        .cpu_data   (cpu_data),
        .sel_oh     (sel_oh),
        .per_fire   (per_fire),
        .mclr_apply (mclr_apply),
        .ch_ack     (ch_ack),
        .ch_ef      (ch_ef),
        .ch_fword   (ch_fword)
    );

    outchan_req #(.NCH(NCH)) u_req (
        .ch_odr  (ch_odr),
        .ch_efr  (ch_efr),
        .sel_oh  (sel_oh),
        .int_now (int_now),
        .cpu_odr (cpu_odr),
        .cpu_efr (cpu_efr)
    );

endmodule

// File: rtl/outchan_mux_chk.sv
// outchan_mux_chk: cycle-level properties of the multiplexer, bound to
// the top module.
module outchan_mux_chk #(
    parameter int NCH = 6,
    parameter int DW  = 30
) (
    input logic           clk,
    input logic           rst_n,
    input logic [DW-1:0]  cpu_data,
    input logic           cpu_ack,
    input logic           cpu_ef,
    input logic           cpu_odr,
    input logic           cpu_efr,
    input logic [NCH-1:0] ch_odr,
    input logic [NCH-1:0] sel_oh,
    input logic [NCH-1:0] ch_ack,
    input logic [NCH-1:0] ch_ef
);

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ack));

    // R6
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_ack) |-> $past(cpu_ack));

    // R7
    ef_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ef));

    // R7
    ef_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_ef) |=> !(|ch_ef));

    // R9
    efr_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ef && cpu_data[DW-1] && !$past(cpu_ef)) |-> !cpu_efr);

    // R4
    odr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_odr |-> (|(ch_odr & sel_oh)));

endmodule

bind outchan_mux outchan_mux_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_data (cpu_data),
    .cpu_ack  (cpu_ack),
    .cpu_ef   (cpu_ef),
    .cpu_odr  (cpu_odr),
    .cpu_efr  (cpu_efr),
    .ch_odr   (ch_odr),
    .sel_oh   (sel_oh),
    .ch_ack   (ch_ack),
    .ch_ef    (ch_ef)
);

// File: tb/outchan_mux_tb.sv
`timescale 1ns/1ps
module outchan_mux_tb;

    localparam int NCH = 6;
    localparam int DW  = 30;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DW-1:0]  cpu_data = '0;
    logic           cpu_ack = 1'b0;
    logic           cpu_ef = 1'b0;
    logic           cpu_odr, cpu_efr;
    logic [NCH-1:0] ch_odr = '0;
    logic [NCH-1:0] ch_efr = '0;
    logic [DW-1:0]  ch_data;
    logic [DW-2:0]  ch_fword;
    logic [NCH-1:0] ch_ack, ch_ef;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    outchan_mux #(.NCH(NCH), .DW(DW)) u_dut (.*);

    // Vector: [39:38] op (0 = internal word then acknowledge, 1 = peripheral
    // function word), [37:8] word, [7:0] expected one-hot strobe.
    localparam logic [39:0] VEC [0:7] = '{
        {2'd0, 30'h2000_0002, 8'h04},   // R3 select 2
        {2'd0, 30'h2000_0005, 8'h20},   // R3 select 5
        {2'd0, 30'h2000_0000, 8'h01},   // R3 select 0
        {2'd0, 30'h2000_0007, 8'h00},   // R11 index 7 out of range
        {2'd0, 30'h2000_0003, 8'h08},   // R3 select 3
        {2'd0, 30'h3000_0003, 8'h00},   // R10 master clear
        {2'd0, 30'h2000_0001, 8'h02},   // R3 select 1
        {2'd1, 30'h00AB_CDEF, 8'h02}    // R7 peripheral word to channel 1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Internal or peripheral pulse held for 'len' cycles; returns after the end takes effect.
    task automatic ef_pulse(input logic [DW-1:0] w, input int len);
        @(negedge clk); cpu_data = w; cpu_ef = 1'b1;
        repeat (len) @(negedge clk);
        cpu_ef = 1'b0;
        @(negedge clk);
    endtask

    task automatic oa_check(input logic [NCH-1:0] exp, input string req);
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); chk(req, 32'(ch_ack), 32'(exp));
        cpu_ack = 1'b0;
        @(negedge clk); chk(req, 32'(ch_ack), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        ch_odr = '1; ch_efr = '1;
        @(negedge clk);
        // R2 reset state
        chk("R2", {30'h0, cpu_odr, cpu_efr}, 32'h0);
        chk("R2", {20'h0, ch_ack, ch_ef}, 32'h0);
        chk("R2", 32'(ch_fword), 32'h0);
        rst_n = 1'b1;
        ch_odr = '0; ch_efr = '0;
        @(negedge clk);

        // Vector walk
        foreach (VEC[k]) begin
            if (VEC[k][39:38] == 2'd0) begin
                ef_pulse(VEC[k][37:8], 2);
                oa_check(VEC[k][NCH-1:0], "R3/R6/R10/R11");
            end else begin
                @(negedge clk); cpu_data = VEC[k][37:8]; cpu_ef = 1'b1;
                @(negedge clk);
                chk("R7", 32'(ch_ef), 32'(VEC[k][NCH-1:0]));
                chk("R7", 32'(ch_fword), 32'(VEC[k][36:8]));
                @(negedge clk);
                chk("R7", 32'(ch_ef), 32'h0);
                cpu_ef = 1'b0;
                @(negedge clk);
            end
        end

        // R1 broadcast
        cpu_data = 30'h3FFF_FFFF; #1 chk("R1", 32'(ch_data), 32'h3FFF_FFFF);
        cpu_data = 30'h1555_5555; #1 chk("R1", 32'(ch_data), 32'h1555_5555);

        // R4 / R5: channel 1 selected, others ignored
        @(negedge clk);
        ch_odr = 6'b111101; ch_efr = 6'b111101;
        #1 chk("R4", 32'(cpu_odr), 32'h0);
        chk("R5", 32'(cpu_efr), 32'h0);
        ch_odr = 6'b000010; ch_efr = 6'b000010;
        #1 chk("R4", 32'(cpu_odr), 32'h1);
        chk("R5", 32'(cpu_efr), 32'h1);

        // R9 / R8 / R12: internal select of channel 4 while channel 1 requests
        @(negedge clk); cpu_data = 30'h2000_0004; cpu_ef = 1'b1;
        #1 chk("R9", 32'(cpu_efr), 32'h0);
        @(negedge clk);
        chk("R9", 32'(cpu_efr), 32'h0);
        chk("R8", 32'(ch_ef), 32'h0);
        chk("R12", 32'(cpu_odr), 32'h1);
        @(negedge clk);
        chk("R8", 32'(ch_fword), 32'h00AB_CDEF);
        cpu_ef = 1'b0;
        #1 chk("R5", 32'(cpu_efr), 32'h1);
        @(negedge clk);
        chk("R3", 32'(cpu_odr), 32'h0);
        ch_odr = 6'b010000;
        #1 chk("R4", 32'(cpu_odr), 32'h1);
        oa_check(6'b010000, "R6");

        // R10: master clear stops forwarding
        ef_pulse(30'h3000_0000, 1);
        chk("R10", 32'(cpu_odr), 32'h0);
        oa_check(6'b000000, "R6");

        // R2: reset clears an active selection
        ef_pulse(30'h2000_0004, 1);
        chk("R3", 32'(cpu_odr), 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); chk("R2", 32'(cpu_odr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk); chk("R2", 32'(cpu_odr), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule